// File: doc/BRIEF.md
# QRS Enhancement Filter Chain

This block is a streaming fixed-point pipeline for single-lead ECG data sampled at 200 Hz. Every accepted 16-bit sample goes through five integer stages in a fixed order: a recursive low-pass, a running-sum high-pass, a two-sample-lag difference, a saturating magnitude and a 16-sample moving mean. The result is a non-negative energy-like trace. In that trace each QRS complex forms one smooth hump, and slow baseline wander and fast noise are largely removed. A beat-decision stage downstream reads this trace. No stage contains a multiplier or a divider. The only operations are additions, subtractions and arithmetic shifts.

Samples arrive with a one-cycle `in_valid` strobe. Each stage holds a single register and advances only when the stage before it hands over a result. A sample therefore moves through the chain in five clock cycles, and the next sample may follow in the very next cycle. Every intermediate result is also brought out on a debug tap. The qualified output strobe is suppressed after reset until the delay lines have been filled.

Top module: `qrs_enhance`

## Requirements
- R1: After reset all four taps, `out_sample` and `out_valid` are zero, and every delay line and accumulator starts from zero.
- R2: For each accepted sample, `tap_lp` updates 1 clock edge after the `in_valid` edge, `tap_hp` after 2, `tap_der` after 3, `tap_abs` after 4, and `out_sample` with a one-cycle `out_valid` pulse after 5.
- R3: `out_valid` stays low for the first 41 samples accepted after reset and pulses for the 42nd and every later sample.
- R4: With y[n] = 2y[n-1] - y[n-2] + x[n] - 2x[n-5] + x[n-10] on the input samples, `tap_lp` = floor(y[n] / 32), saturated to the signed 16-bit range.
- R5: With s[n] as the sum of the latest 26 `tap_lp` values, `tap_hp` = lp[n-13] - floor(s[n] / 32), saturated to signed 16 bits.
- R6: `tap_der` = hp[n] - hp[n-2], saturated to signed 16 bits.
- R7: `tap_abs` is the magnitude of `tap_der`. The code -32768 maps to 32767, so `tap_abs` is never negative.
- R8: `out_sample` = floor(sum of the latest 16 `tap_abs` values / 16) and is never negative.
- R9: In a cycle with no new sample reaching a stage, that stage's tap and `out_sample` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | One-cycle strobe that accepts `in_sample` |
| in_sample | input | 16 | Signed two's-complement ECG sample |
| out_valid | output | 1 | One-cycle strobe for a qualified `out_sample` |
| out_sample | output | 16 | Moving-mean output (signed type, always non-negative) |
| tap_lp | output | 16 | Low-pass stage result |
| tap_hp | output | 16 | High-pass stage result |
| tap_der | output | 16 | Difference stage result |
| tap_abs | output | 16 | Magnitude stage result |

## Verification
The recursive low-pass and the high-pass running sum keep internal state for an unlimited time. A single wrong update in either one therefore leaves a permanent offset. That offset shows on `tap_lp` or `tap_hp` for every later sample, not only on the one that caused it. Errors in the delay lines appear exactly 2, 5, 10, 13, 16 or 26 samples after the affected input. Impulse and step inputs expose each of these lags at its own position. A wrong warm-up count moves the first `out_valid` pulse away from the 42nd sample. A wrong pipeline alignment moves the pulse away from the fifth edge after the strobe.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
    localparam int SAMPLE_W = 16;
    localparam logic signed [SAMPLE_W-1:0] S_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [SAMPLE_W-1:0] S_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

    // clamp a wide signed value into the sample range
    function automatic logic signed [SAMPLE_W-1:0] clip(input logic signed [31:0] v);
        if (v > 32'(S_MAX))      return S_MAX;
        else if (v < 32'(S_MIN)) return S_MIN;
        else                     return v[SAMPLE_W-1:0];
    endfunction
endpackage

// File: rtl/qrs_lowpass.sv
module qrs_lowpass import qrs_pkg::*; #(
    parameter int ACC_W = SAMPLE_W + 8,
    parameter int SHIFT = 5,
    parameter int GAP   = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_vld,
    input  logic signed [SAMPLE_W-1:0] in_x,
    output logic                       out_vld,
    output logic signed [SAMPLE_W-1:0] out_y
);
    localparam int DEPTH = 2 * GAP;

    typedef struct packed {
        logic [DEPTH-1:0][SAMPLE_W-1:0] hist;
        logic signed [ACC_W-1:0]        y1;
        logic signed [ACC_W-1:0]        y2;
        logic signed [SAMPLE_W-1:0]     y;
        logic                           vld;
    } lp_state_t;

    lp_state_t st_d, st_q;
    logic signed [ACC_W-1:0] y_new;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        y_new    = '0;
        if (in_vld) begin
            y_new = (st_q.y1 <<< 1) - st_q.y2 + ACC_W'(in_x)
                  - (ACC_W'($signed(st_q.hist[GAP-1])) <<< 1)
                  + ACC_W'($signed(st_q.hist[DEPTH-1]));
            st_d.y2 = st_q.y1;
            st_d.y1 = y_new;
            st_d.y  = clip(32'(y_new >>> SHIFT));
            st_d.hist[0] = in_x;
            for (int i = 1; i < DEPTH; i++) st_d.hist[i] = st_q.hist[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign out_y   = st_q.y;
endmodule

// File: rtl/qrs_highpass.sv
module qrs_highpass import qrs_pkg::*; #(
    parameter int ACC_W = SAMPLE_W + 6,
    parameter int SHIFT = 5,
    parameter int LEN   = 26
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_vld,
    input  logic signed [SAMPLE_W-1:0] in_x,
    output logic                       out_vld,
    output logic signed [SAMPLE_W-1:0] out_z
);
    localparam int MID = LEN / 2;

    typedef struct packed {
        logic [LEN-1:0][SAMPLE_W-1:0] hist;
        logic signed [ACC_W-1:0]      sum;
        logic signed [SAMPLE_W-1:0]   z;
        logic                         vld;
    } hp_state_t;

    hp_state_t st_d, st_q;
    logic signed [ACC_W-1:0] sum_new;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        sum_new  = '0;
        if (in_vld) begin
            sum_new  = st_q.sum + ACC_W'(in_x) - ACC_W'($signed(st_q.hist[LEN-1]));
            st_d.sum = sum_new;
            st_d.z   = clip(32'($signed(st_q.hist[MID-1])) - 32'(sum_new >>> SHIFT));
            st_d.hist[0] = in_x;
            for (int i = 1; i < LEN; i++) st_d.hist[i] = st_q.hist[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign out_z   = st_q.z;
endmodule

// File: rtl/qrs_movavg.sv
module qrs_movavg import qrs_pkg::*; #(
    parameter int LOG2_LEN = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_vld,
    input  logic signed [SAMPLE_W-1:0] in_x,
    output logic                       out_vld,
    output logic signed [SAMPLE_W-1:0] out_m
);
    localparam int LEN   = 1 << LOG2_LEN;
    localparam int ACC_W = SAMPLE_W + LOG2_LEN + 1;

    typedef struct packed {
        logic [LEN-1:0][SAMPLE_W-1:0] hist;
        logic signed [ACC_W-1:0]      sum;
        logic signed [SAMPLE_W-1:0]   m;
        logic                         vld;
    } ma_state_t;

    ma_state_t st_d, st_q;
    logic signed [ACC_W-1:0] sum_new;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        sum_new  = '0;
        if (in_vld) begin
            sum_new  = st_q.sum + ACC_W'(in_x) - ACC_W'($signed(st_q.hist[LEN-1]));
            st_d.sum = sum_new;
            st_d.m   = clip(32'(sum_new >>> LOG2_LEN));
            st_d.hist[0] = in_x;
            for (int i = 1; i < LEN; i++) st_d.hist[i] = st_q.hist[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign out_m   = st_q.m;
endmodule

// File: rtl/qrs_enhance.sv
module qrs_enhance import qrs_pkg::*; #(
    parameter int LP_ACC_W = SAMPLE_W + 8,
    parameter int LP_SHIFT = 5,
    parameter int LP_GAP   = 5,
    parameter int HP_ACC_W = SAMPLE_W + 6,
    parameter int HP_SHIFT = 5,
    parameter int HP_LEN   = 26,
    parameter int DER_LAG  = 2,
    parameter int AVG_LOG2 = 4,
    parameter int WARMUP   = HP_LEN + (1 << AVG_LOG2)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_sample,
    output logic signed [SAMPLE_W-1:0] tap_lp,
    output logic signed [SAMPLE_W-1:0] tap_hp,
    output logic signed [SAMPLE_W-1:0] tap_der,
    output logic signed [SAMPLE_W-1:0] tap_abs
);
    localparam int STAGES = 5;
    localparam int CNT_W  = $clog2(WARMUP + 1);

    typedef struct packed {
        logic [CNT_W-1:0]                 cnt;
        logic [STAGES-1:0]                ready;
        logic [DER_LAG-1:0][SAMPLE_W-1:0] prev;
        logic signed [SAMPLE_W-1:0]       der;
        logic                             der_vld;
        logic signed [SAMPLE_W-1:0]       mag;
        logic                             mag_vld;
    } top_state_t;

    top_state_t st_d, st_q;

    logic                       lp_vld, hp_vld, avg_vld;
    logic signed [SAMPLE_W-1:0] lp_y, hp_z, avg_m;

    qrs_lowpass #(.ACC_W(LP_ACC_W), .SHIFT(LP_SHIFT), .GAP(LP_GAP)) u_lp (
        .clk(clk), .rst_n(rst_n), .in_vld(in_valid), .in_x(in_sample),
        .out_vld(lp_vld), .out_y(lp_y)
    );

    qrs_highpass #(.ACC_W(HP_ACC_W), .SHIFT(HP_SHIFT), .LEN(HP_LEN)) u_hp (
        .clk(clk), .rst_n(rst_n), .in_vld(lp_vld), .in_x(lp_y),
        .out_vld(hp_vld), .out_z(hp_z)
    );

    always_comb begin
        st_d         = st_q;
        st_d.der_vld = hp_vld;
        st_d.mag_vld = st_q.der_vld;
        // warm-up qualification travels alongside the sample
        st_d.ready   = {st_q.ready[STAGES-2:0],
                        in_valid && (32'(st_q.cnt) >= WARMUP - 1)};
        if (in_valid && (32'(st_q.cnt) < WARMUP))
            st_d.cnt = st_q.cnt + 1'b1;
        if (hp_vld) begin
            st_d.der = clip(32'(hp_z) - 32'($signed(st_q.prev[DER_LAG-1])));
            st_d.prev[0] = hp_z;
            for (int i = 1; i < DER_LAG; i++) st_d.prev[i] = st_q.prev[i-1];
        end
        if (st_q.der_vld) begin
            if (st_q.der == S_MIN)   st_d.mag = S_MAX;
            else if (st_q.der < 0)   st_d.mag = -st_q.der;
            else                     st_d.mag = st_q.der;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    qrs_movavg #(.LOG2_LEN(AVG_LOG2)) u_avg (
        .clk(clk), .rst_n(rst_n), .in_vld(st_q.mag_vld), .in_x(st_q.mag),
        .out_vld(avg_vld), .out_m(avg_m)
    );

    assign out_valid  = avg_vld && st_q.ready[STAGES-1];
    assign out_sample = avg_m;
    assign tap_lp     = lp_y;
    assign tap_hp     = hp_z;
    assign tap_der    = st_q.der;
    assign tap_abs    = st_q.mag;
endmodule

// File: rtl/qrs_enhance_chk.sv
module qrs_enhance_chk import qrs_pkg::*; (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       out_valid,
    input logic signed [SAMPLE_W-1:0] out_sample,
    input logic signed [SAMPLE_W-1:0] tap_lp,
    input logic signed [SAMPLE_W-1:0] tap_hp,
    input logic signed [SAMPLE_W-1:0] tap_abs
);
    // R2
    out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 5));

    // R7
    abs_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tap_abs[SAMPLE_W-1]);

    // R8
    avg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_sample[SAMPLE_W-1]);

    // R9
    lp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> $stable(tap_lp));

    // R9
    hp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid, 2) |-> $stable(tap_hp));
endmodule

bind qrs_enhance qrs_enhance_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .out_sample(out_sample), .tap_lp(tap_lp), .tap_hp(tap_hp), .tap_abs(tap_abs)
);

// File: tb/qrs_enhance_tb.sv
module qrs_enhance_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic out_valid;
    logic signed [15:0] out_sample, tap_lp, tap_hp, tap_der, tap_abs;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    int accepted = 0;
    int xq[$], lq[$], hq[$], dq[$], aq[$];

    always #4 clk = ~clk;

    qrs_enhance u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_sample(out_sample),
        .tap_lp(tap_lp), .tap_hp(tap_hp), .tap_der(tap_der), .tap_abs(tap_abs)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int pick(input int q[$], input int back);
        if (back >= q.size()) return 0;
        return q[q.size() - 1 - back];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        xq.delete(); lq.delete(); hq.delete(); dq.delete(); aq.delete();
        accepted = 0;
        @(negedge clk);
        // R1 everything cleared
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "out_sample", int'(out_sample), 0);
        chk("R1", "tap_lp", int'(tap_lp), 0);
        chk("R1", "tap_hp", int'(tap_hp), 0);
        chk("R1", "tap_der", int'(tap_der), 0);
        chk("R1", "tap_abs", int'(tap_abs), 0);
    endtask

    task automatic feed(input int x);
        int y, s, lpv, hpv, dv, av, mv, snap_lp, snap_out;
        bit exp_ov;
        xq.push_back(x);
        y = 0;
        // low-pass as its equivalent 9-tap triangle
        for (int k = 0; k < 9; k++) y += ((k + 1 < 9 - k) ? k + 1 : 9 - k) * pick(xq, k);
        lpv = sat(y >>> 5);
        lq.push_back(lpv);
        s = 0;
        for (int k = 0; k < 26; k++) s += pick(lq, k);
        hpv = sat(pick(lq, 13) - (s >>> 5));
        hq.push_back(hpv);
        dv = sat(pick(hq, 0) - pick(hq, 2));
        dq.push_back(dv);
        av = (dv == -32768) ? 32767 : ((dv < 0) ? -dv : dv);
        aq.push_back(av);
        s = 0;
        for (int k = 0; k < 16; k++) s += pick(aq, k);
        mv = sat(s >>> 4);
        accepted++;
        exp_ov = (accepted >= 42);
        snap_lp = 0; snap_out = 0;

        @(negedge clk);
        in_sample = 16'(x);
        in_valid  = 1'b1;
        for (int i = 1; i <= 7; i++) begin
            @(negedge clk);
            if (i == 1) in_valid = 1'b0;
            if (i == 5) begin
                // R2 R3 pulse on fifth edge only when warmed up
                chk("R3", "out_valid", int'(out_valid), int'(exp_ov));
                chk("R8", "out_sample", int'(out_sample), mv);
                snap_lp = int'(tap_lp);
                snap_out = int'(out_sample);
            end else begin
                chk("R2", "out_valid idle", int'(out_valid), 0);
            end
        end
        chk("R4", "tap_lp", int'(tap_lp), lpv);
        chk("R5", "tap_hp", int'(tap_hp), hpv);
        chk("R6", "tap_der", int'(tap_der), dv);
        chk("R7", "tap_abs", int'(tap_abs), av);
        chk("R9", "tap_lp held", int'(tap_lp), snap_lp);
        chk("R9", "out_sample held", int'(out_sample), snap_out);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // impulse
        feed(8000);
        for (int n = 0; n < 60; n++) feed(0);
        // step, then a mid-stream reset
        do_reset();
        for (int n = 0; n < 70; n++) feed(12000);
        do_reset();
        // periodic QRS-like pulse train on a drifting baseline
        for (int n = 0; n < 160; n++) begin
            int k = n % 40;
            int v = (n % 20) * 50;
            if (k < 5)       v += k * 6000;
            else if (k < 9)  v += 24000 - (k - 4) * 7500;
            feed(v);
        end
        do_reset();
        // full-scale square wave to drive the saturation paths
        for (int n = 0; n < 120; n++) feed(((n / 7) % 2 == 0) ? 32767 : -32768);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule